// File: doc/BRIEF.md
# Four-Channel Bridge Drive Sequencer

This block turns a small set of written control registers into the gate-level inputs of four H-bridge motor drivers. Every channel has three outputs: two bridge inputs (`drv_in1`, `drv_in2`) and a bridge enable (`drv_en`). One direction bit per channel sets both bridge inputs, so the two inputs of a channel always disagree while the channel is driving. An enable bit per channel chooses between driving and coasting. A separate brake bit forces a short-circuit brake.

Speed comes from pulse-width modulation on the enable line. One shared timebase divides the clock by a programmable prescaler and walks a 255-step counter. Each channel compares its own 8-bit duty value with that counter. Duty, direction and enable values are held in per-channel shadow copies that are refreshed only when the counter wraps. A new setting therefore never cuts a pulse short or flips the bridge mid-pulse. The brake bit bypasses the shadow and acts at once.

The PWM frequency is `f_clk / (255 * (P + 1))`, where P is the 16-bit prescaler. With a 50 MHz clock, P values from about 195 to about 3920 cover 1 kHz down to 50 Hz.

Top module: `hbridge_quad`

## Requirements
- R1: While a channel is enabled and not braking, direction bit 1 gives `drv_in1`=0 and `drv_in2`=1, and direction bit 0 gives `drv_in1`=1 and `drv_in2`=0. This holds in both phases of the PWM.
- R2: On no channel and in no cycle are `drv_in1` and `drv_in2` both 1.
- R3: Brake register (address 5, bit i for channel i) set: the channel outputs `drv_in1`=0, `drv_in2`=0 and `drv_en`=1 from the second rising edge after the write. This overrides enable, direction and duty.
- R4: Enable bit clear (address 4, bit i) and brake clear: the channel coasts, with all three of its outputs at 0.
- R5: Duty value d (address i for channel i, 8 bits) on an enabled channel gives exactly d*(P+1) cycles of `drv_en` high in every run of 255*(P+1) consecutive cycles. For example, 64 gives 25%, 128 gives 50% and 192 gives 75%.
- R6: Duty 0 keeps `drv_en` permanently low. Duty 255 keeps `drv_en` permanently high, with no gaps at the period boundary.
- R7: The PWM period is 255*(P+1) clocks. P is a 16-bit prescaler whose low byte is at address 6 and high byte at address 7. One high pulse at duty d lasts d*(P+1) cycles.
- R8: Direction bits (address 4, bits 4+i), enable bits and duty values written mid-period change the outputs only after the next period boundary.
- R9: After synchronous reset, all twelve driver outputs are 0 and all registers, including P, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| drv_in1 | output | 4 | Bridge input 1, one bit per channel |
| drv_in2 | output | 4 | Bridge input 2, one bit per channel |
| drv_en | output | 4 | Bridge enable (PWM), one bit per channel |

## Verification
The assertions check the following on every cycle:
- the two bridge inputs of a channel are never both high;
- brake and coast each produce their fixed output pattern one cycle after they apply;
- duty 0 and duty 255 never let the enable glitch;
- a live direction that differs from the active one does not reach the outputs except at a wrap;
- the timebase counter stays in range and restarts after each wrap.

Some behaviours cover a whole period, or depend on the register map and on when a write lands, and only the bench scenarios can show them. These are the measured on-time fractions at 25%, 50% and 75%, the pulse length under two prescaler settings, and the deferral of a direction change until the next boundary.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;
  localparam int DUTY_W = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_MAX = (1 << DUTY_W) - 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_BRAKE  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_DIV_LO = 3'd6;
  localparam logic [ADDR_W-1:0] ADR_DIV_HI = 3'd7;

  typedef struct packed {
    logic              run;
    logic              dir;
    logic [DUTY_W-1:0] duty;
  } chan_cfg_t;
endpackage

// File: rtl/hbridge_regs.sv
module hbridge_regs
  import hbridge_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int DIV_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DUTY_W-1:0]      wr_data,
  output chan_cfg_t [N_CH-1:0]   cfg_o,
  output logic [N_CH-1:0]        brake_o,
  output logic [DIV_W-1:0]       div_o
);
  chan_cfg_t [N_CH-1:0] cfg_q;
  logic [N_CH-1:0]      brake_q;
  logic [DIV_W-1:0]     div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      brake_q <= '0;
      div_q   <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N_CH; i++) begin
        if (wr_addr == ADDR_W'(i)) cfg_q[i].duty <= wr_data;
      end
      if (wr_addr == ADR_CTRL) begin
        for (int i = 0; i < N_CH; i++) begin
          cfg_q[i].run <= wr_data[i];
          cfg_q[i].dir <= wr_data[4+i];
        end
      end
      if (wr_addr == ADR_BRAKE) brake_q <= wr_data[N_CH-1:0];
      if (wr_addr == ADR_DIV_LO) div_q[7:0] <= wr_data;
      if (wr_addr == ADR_DIV_HI) div_q[DIV_W-1:8] <= wr_data[DIV_W-9:0];
    end
  end

  assign cfg_o   = cfg_q;
  assign brake_o = brake_q;
  assign div_o   = div_q;
endmodule

// File: rtl/hbridge_timebase.sv
module hbridge_timebase
  import hbridge_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic              wrap_o
);
  logic [DIV_W-1:0]  pre_q;
  logic [DUTY_W-1:0] cnt_q;
  logic              tick;

  assign tick = (pre_q >= div_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= (cnt_q == DUTY_W'(CNT_MAX)) ? '0 : cnt_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick && (cnt_q == DUTY_W'(CNT_MAX));

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= DUTY_W'(CNT_MAX)); // R7
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/hbridge_chan.sv
module hbridge_chan
  import hbridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  chan_cfg_t         cfg_i,
  input  logic              brake_i,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic              wrap_i,
  output logic              in1_o,
  output logic              in2_o,
  output logic              en_o
);
  chan_cfg_t sh_q;
  logic      in1_d, in2_d, en_d;
  logic      in1_q, in2_q, en_q;

  always_ff @(posedge clk) begin
    if (rst)         sh_q <= '0;
    else if (wrap_i) sh_q <= cfg_i;
  end

  always_comb begin
    if (brake_i) begin
      in1_d = 1'b0;
      in2_d = 1'b0;
      en_d  = 1'b1;
    end else if (!sh_q.run) begin
      in1_d = 1'b0;
      in2_d = 1'b0;
      en_d  = 1'b0;
    end else begin
      in1_d = ~sh_q.dir;
      in2_d = sh_q.dir;
      en_d  = (cnt_i < sh_q.duty);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in1_q <= 1'b0;
      in2_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      in1_q <= in1_d;
      in2_q <= in2_d;
      en_q  <= en_d;
    end
  end

  assign in1_o = in1_q;
  assign in2_o = in2_q;
  assign en_o  = en_q;

  AST_LEG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(in1_q && in2_q)); // R2
  AST_BRAKE_WINS: assert property (@(posedge clk) disable iff (rst)
    brake_i |=> (en_q && !in1_q && !in2_q)); // R3
  AST_COAST: assert property (@(posedge clk) disable iff (rst)
    (!brake_i && !sh_q.run) |=> (!en_q && !in1_q && !in2_q)); // R4
  AST_DUTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!brake_i && sh_q.duty == '0) |=> !en_q); // R6
  AST_DUTY_FULL: assert property (@(posedge clk) disable iff (rst)
    (!brake_i && sh_q.run && (&sh_q.duty)) |=> en_q); // R6
  AST_DIR_DEFER: assert property (@(posedge clk) disable iff (rst)
    (!brake_i && sh_q.run && !wrap_i && cfg_i.dir != sh_q.dir)
      |=> (in2_q != $past(cfg_i.dir))); // R8
endmodule

// File: rtl/hbridge_quad.sv
module hbridge_quad
  import hbridge_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int DIV_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [2:0]             wr_addr,
  input  logic [7:0]             wr_data,
  output logic [N_CH-1:0]        drv_in1,
  output logic [N_CH-1:0]        drv_in2,
  output logic [N_CH-1:0]        drv_en
);
  chan_cfg_t [N_CH-1:0] cfg;
  logic [N_CH-1:0]      brake;
  logic [DIV_W-1:0]     div;
  logic [DUTY_W-1:0]    cnt;
  logic                 wrap;

  hbridge_regs #(.N_CH(N_CH), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_o(cfg), .brake_o(brake), .div_o(div)
  );

  hbridge_timebase #(.DIV_W(DIV_W)) u_tb (
    .clk(clk), .rst(rst), .div_i(div), .cnt_o(cnt), .wrap_o(wrap)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    hbridge_chan u_ch (
      .clk(clk), .rst(rst), .cfg_i(cfg[g]), .brake_i(brake[g]),
      .cnt_i(cnt), .wrap_i(wrap),
      .in1_o(drv_in1[g]), .in2_o(drv_in2[g]), .en_o(drv_en[g])
    );
  end
endmodule

// File: tb/hbridge_quad_bench.sv
module hbridge_quad_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 100000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] drv_in1, drv_in2, drv_en;

  int checks = 0;
  int errors = 0;
  int leg_viol = 0;
  int cyc = 0;

  string tag_q[$];
  int    val_q[$];

  hbridge_quad u_hbridge_quad (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .drv_in1(drv_in1), .drv_in2(drv_in2), .drv_en(drv_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (!rst && |(drv_in1 & drv_in2)) leg_viol++;
    if (cyc > WDOG_CYC) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG_CYC);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expect_val(input string tag, input int val);
    tag_q.push_back(tag);
    val_q.push_back(val);
  endtask

  task automatic observe(input int actual);
    string t;
    int    e;
    t = tag_q.pop_front();
    e = val_q.pop_front();
    checks++;
    if (actual != e) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, actual, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_high(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (drv_en[ch]) hi++;
    end
  endtask

  task automatic pulse_len(input int ch, output int len);
    len = 0;
    while (drv_en[ch]) @(negedge clk);
    while (!drv_en[ch]) @(negedge clk);
    while (drv_en[ch]) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int hi;
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    expect_val("R9 en after reset", 0);   observe(int'(drv_en));
    expect_val("R9 in1 after reset", 0);  observe(int'(drv_in1));
    expect_val("R9 in2 after reset", 0);  observe(int'(drv_in2));

    // P = 1 -> period 510 clocks
    wr(3'd6, 8'd1);
    wr(3'd7, 8'd0);
    wr(3'd0, 8'd128);
    wr(3'd1, 8'd64);
    wr(3'd2, 8'd192);
    wr(3'd3, 8'd255);
    wr(3'd4, 8'h5F);   // all enabled, dir ch0=1 ch2=1

    // R8: wait for the boundary that loads the settings
    while (!drv_en[3]) @(negedge clk);
    wr(3'd4, 8'h4F);   // ch0 direction to 0 mid-period
    wait_cyc(400);
    expect_val("R8 ch0 in2 before boundary", 1); observe(int'(drv_in2[0]));
    wait_cyc(150);
    expect_val("R8 ch0 in2 after boundary", 0);  observe(int'(drv_in2[0]));

    expect_val("R1 ch0 dir0 in1", 1); observe(int'(drv_in1[0]));
    expect_val("R1 ch2 dir1 in2/in1", 2);
    observe(int'({drv_in2[2], drv_in1[2]}));

    expect_val("R5 ch0 duty128", 256); count_high(0, 510, hi); observe(hi);
    expect_val("R5 ch1 duty64", 128);  count_high(1, 510, hi); observe(hi);
    expect_val("R5 ch2 duty192", 384); count_high(2, 510, hi); observe(hi);
    expect_val("R6 ch3 duty255", 510); count_high(3, 510, hi); observe(hi);
    expect_val("R7 ch1 pulse P1", 128); pulse_len(1, hi); observe(hi);

    wr(3'd1, 8'd0);
    wait_cyc(1100);
    expect_val("R6 ch1 duty0", 0); count_high(1, 510, hi); observe(hi);

    wr(3'd5, 8'h04);
    @(negedge clk);
    expect_val("R3 ch2 brake pattern", 4);
    observe(int'({drv_en[2], drv_in2[2], drv_in1[2]}));
    expect_val("R3 ch2 brake en held", 510); count_high(2, 510, hi); observe(hi);
    wr(3'd5, 8'h00);

    wr(3'd4, 8'h4E);   // ch0 enable off
    wait_cyc(1100);
    expect_val("R4 ch0 coast pattern", 0);
    observe(int'({drv_en[0], drv_in2[0], drv_in1[0]}));
    expect_val("R4 ch0 coast en", 0); count_high(0, 510, hi); observe(hi);

    // P = 3 -> period 1020 clocks
    wr(3'd6, 8'd3);
    wait_cyc(2100);
    expect_val("R7 ch2 pulse P3", 768);  pulse_len(2, hi); observe(hi);
    expect_val("R5 ch2 window P3", 768); count_high(2, 1020, hi); observe(hi);

    expect_val("R2 leg overlap cycles", 0); observe(leg_viol);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule